// File: doc/BRIEF.md
# Super I/O Configuration Register File

This block holds the configuration space of a legacy multi-function I/O controller. A byte-wide host reaches it through two port addresses. One address is the index port and selects a register. The other is the data port and reads or writes the selected register. The space starts out locked. While it is locked, the host sees only zeros and can do nothing except present an unlock key byte on the index port. A second key byte on the index port locks the space again.

Register numbers below 0x30 form one global area that every logical device sees. Register numbers 0x30 and above are banked. Each of the up to 16 logical devices has its own copy, and a device-select number taken from global register 0x07 picks the copy. That number is refreshed whenever any global register is written. Read data comes back registered. The peripheral functions that would use these registers are not part of this block.

Top module: `superio_cfg_regs`

## Requirements
- R1: After reset the space is locked. Every read returns 0x00 one cycle after the read strobe, and index-port writes other than 0x55 change no state.
- R2: Writing 0x55 to the index port (port_sel = 0) while locked unlocks the space. The index register keeps its value, which is 0x00 after reset.
- R3: Writing 0xAA to the index port while unlocked locks the space and leaves the index register unchanged.
- R4: While unlocked, any other index-port write loads the 8-bit index, including 0x55. A read of the index port returns the index.
- R5: Data-port (port_sel = 1) accesses with index below 0x30 reach a single global bank. That bank holds the same contents whichever device is selected.
- R6: Data-port accesses with index 0x30 or above reach the bank of the currently selected device. A write to one device's bank leaves the other banks unchanged.
- R7: Every data write to the global bank loads the device-select number from global register 0x07, using the value that register holds after the write.
- R8: After reset, global register 0x26 reads 0x2E and every other register reads 0x00.
- R9: rd_data changes only on the clock edge that samples rd_en high. Between reads it holds its last value.
- R10: The device-select number is the low 4 bits of register 0x07, so 0x13 selects device 3. Register 0x07 itself reads back all 8 bits.
- R11: Data-port writes while locked change no register, register 0x07 included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| port_sel | input | 1 | 0 = index port, 1 = data port |
| wr_en | input | 1 | Write strobe for the selected port |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe for the selected port |
| rd_data | output | 8 | Registered read byte, valid one cycle after rd_en |

## Verification
The inline assertions watch the key handling on every cycle. They check that 0x55 unlocks, that 0xAA locks without touching the index, and that the index stays frozen while the space is locked. They also check that locked reads yield zero, that rd_data holds between strobes, that writes to register 0x07 load the low bits of the select, and that banked writes leave the select alone. Only the bench's scenarios can show that data lands in the right bank and stays there. They also show that the global area is shared across device selections, that the reset value of register 0x26 is present, and that locked data writes leave no trace after the space is unlocked again.

// File: rtl/superio_cfg_pkg.sv
package superio_cfg_pkg;

    localparam int BYTE_W      = 8;
    localparam int GLOBAL_TOP  = 48;          // first banked register number (0x30)
    localparam int REG_SPACE   = 256;
    localparam int BANK_DEPTH  = REG_SPACE - GLOBAL_TOP;
    localparam int GLB_AW      = $clog2(GLOBAL_TOP);

    localparam logic [BYTE_W-1:0] KEY_OPEN  = 8'h55;
    localparam logic [BYTE_W-1:0] KEY_CLOSE = 8'hAA;
    localparam logic [BYTE_W-1:0] SEL_REG   = 8'h07;
    localparam logic [BYTE_W-1:0] ID_REG    = 8'h26;
    localparam logic [BYTE_W-1:0] ID_RESET  = 8'h2E;

    typedef enum logic {PORT_INDEX = 1'b0, PORT_DATA = 1'b1} port_e;
    typedef enum logic {ST_LOCKED = 1'b0, ST_OPEN = 1'b1} lock_e;

    typedef struct packed {
        port_e               port;
        logic                wr;
        logic                rd;
        logic [BYTE_W-1:0]   data;
    } host_req_t;

    function automatic logic is_global(input logic [BYTE_W-1:0] idx);
        return int'(idx) < GLOBAL_TOP;
    endfunction

    function automatic logic [BYTE_W-1:0] global_reset(input int num);
        return (num == int'(ID_REG)) ? ID_RESET : '0;
    endfunction

endpackage

// File: rtl/superio_key_fsm.sv
module superio_key_fsm
    import superio_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              idx_wr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              unlocked,
    output logic [BYTE_W-1:0] index
);

    lock_e             state_q;
    logic [BYTE_W-1:0] index_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOCKED;
            index_q <= '0;
        end else if (idx_wr) begin
            unique case (state_q)
                ST_LOCKED: begin
                    if (wr_data == KEY_OPEN) state_q <= ST_OPEN;
                end
                ST_OPEN: begin
                    if (wr_data == KEY_CLOSE) state_q <= ST_LOCKED;
                    else                      index_q <= wr_data;
                end
                default: state_q <= ST_LOCKED;
            endcase
        end
    end

    assign unlocked = (state_q == ST_OPEN);
    assign index    = index_q;

    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
        (!unlocked && idx_wr && wr_data == KEY_OPEN) |=> unlocked); // R2

    AST_KEY_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (unlocked && idx_wr && wr_data == KEY_CLOSE) |=> (!unlocked && $stable(index))); // R3

    AST_LOCKED_INDEX_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!unlocked) |=> $stable(index)); // R1

endmodule

// File: rtl/superio_bank_store.sv
module superio_bank_store
    import superio_cfg_pkg::*;
#(
    parameter int NUM_DEV = 16
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] index,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_byte
);

    localparam int SEL_W     = $clog2(NUM_DEV);
    localparam int MEM_DEPTH = NUM_DEV * BANK_DEPTH;
    localparam int MEM_AW    = $clog2(MEM_DEPTH);

    logic [BYTE_W-1:0] glob_q [GLOBAL_TOP];
    logic [BYTE_W-1:0] dev_q  [MEM_DEPTH];
    logic [SEL_W-1:0]  dev_sel_q;
    logic [MEM_AW-1:0] dev_addr;
    logic [GLB_AW-1:0] glob_addr;
    logic              hit_global;

    assign hit_global = is_global(index);
    assign glob_addr  = index[GLB_AW-1:0];
    assign dev_addr   = MEM_AW'(dev_sel_q) * MEM_AW'(BANK_DEPTH)
                      + MEM_AW'(index - BYTE_W'(GLOBAL_TOP));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < GLOBAL_TOP; g++) glob_q[g] <= global_reset(g);
            for (int d = 0; d < MEM_DEPTH; d++)  dev_q[d]  <= '0;
            dev_sel_q <= '0;
        end else if (wr_en) begin
            if (hit_global) begin
                glob_q[glob_addr] <= wr_data;
                dev_sel_q <= (index == SEL_REG) ? wr_data[SEL_W-1:0]
                                                : glob_q[SEL_REG[GLB_AW-1:0]][SEL_W-1:0];
            end else begin
                dev_q[dev_addr] <= wr_data;
            end
        end
    end

    assign rd_byte = hit_global ? glob_q[glob_addr] : dev_q[dev_addr];

    AST_SEL_FROM_REG7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && index == SEL_REG) |=> (dev_sel_q == $past(wr_data[SEL_W-1:0]))); // R10

    AST_BANK_WR_KEEPS_SEL: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hit_global) |=> $stable(dev_sel_q)); // R6

endmodule

// File: rtl/superio_cfg_regs.sv
module superio_cfg_regs
    import superio_cfg_pkg::*;
#(
    parameter int NUM_DEV = 16
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       port_sel,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data
);

    host_req_t         req;
    logic              unlocked;
    logic [BYTE_W-1:0] index;
    logic [BYTE_W-1:0] store_byte;
    logic [BYTE_W-1:0] rd_q;
    logic              data_wr;

    assign req.port = port_e'(port_sel);
    assign req.wr   = wr_en;
    assign req.rd   = rd_en;
    assign req.data = wr_data;

    assign data_wr = unlocked && req.wr && (req.port == PORT_DATA);

    superio_key_fsm u_key (
        .clk      (clk),
        .rst      (rst),
        .idx_wr   (req.wr && req.port == PORT_INDEX),
        .wr_data  (req.data),
        .unlocked (unlocked),
        .index    (index)
    );

    superio_bank_store #(.NUM_DEV(NUM_DEV)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (data_wr),
        .index   (index),
        .wr_data (req.data),
        .rd_byte (store_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (req.rd) begin
            if (!unlocked)                 rd_q <= '0;
            else if (req.port == PORT_DATA) rd_q <= store_byte;
            else                           rd_q <= index;
        end
    end

    assign rd_data = rd_q;

    AST_LOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !unlocked) |=> (rd_data == 8'h00)); // R1

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rd_en) |=> $stable(rd_data)); // R9

endmodule

// File: tb/superio_cfg_regs_tb.sv
module superio_cfg_regs_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       port_sel = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;

    always #2.5 clk = ~clk;  // 200 MHz

    superio_cfg_regs dut_i (
        .clk(clk), .rst(rst), .port_sel(port_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
    );

    // behavioural reference model
    int        n_checks = 0;
    int        n_errors = 0;
    bit        m_open;
    int        m_index;
    int        m_sel;
    int        m_glob [48];
    int        m_bank [int];
    int        exp_rd;
    string     cur_req = "R1";
    int        cycles = 0;

    function automatic int m_read_data();
        if (m_index < 48) return m_glob[m_index];
        if (m_bank.exists(m_sel * 256 + m_index)) return m_bank[m_sel * 256 + m_index];
        return 0;
    endfunction

    task automatic check_out();
        n_checks++;
        if (rd_data !== exp_rd[7:0]) begin
            n_errors++;
            $display("FAIL %s: rd_data actual=%02h expected=%02h", cur_req, rd_data, exp_rd[7:0]);
        end
    endtask

    // one bus cycle: compare last result, then drive and advance the model
    task automatic op(input bit p, input bit w, input int d, input bit r);
        @(negedge clk);
        check_out();
        port_sel = p; wr_en = w; wr_data = d[7:0]; rd_en = r;
        if (r) exp_rd = !m_open ? 0 : (p ? m_read_data() : m_index);
        if (w) begin
            if (!p) begin
                if (!m_open) begin
                    if (d == 'h55) m_open = 1;
                end else if (d == 'hAA) m_open = 0;
                else m_index = d;
            end else if (m_open) begin
                if (m_index < 48) begin
                    m_glob[m_index] = d;
                    m_sel = m_glob[7] % 16;
                end else m_bank[m_sel * 256 + m_index] = d;
            end
        end
    endtask

    task automatic idle(); op(0, 0, 0, 0); endtask
    task automatic wr_idx(input int d); op(0, 1, d, 0); endtask
    task automatic wr_dat(input int d); op(1, 1, d, 0); endtask
    task automatic rd_idx(); op(0, 0, 0, 1); endtask
    task automatic rd_dat(); op(1, 0, 0, 1); endtask
    task automatic put(input int i, input int d); wr_idx(i); wr_dat(d); endtask
    task automatic get(input int i); wr_idx(i); rd_dat(); idle(); endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    initial begin
        m_open = 0; m_index = 0; m_sel = 0; exp_rd = 0;
        foreach (m_glob[k]) m_glob[k] = 0;
        m_glob['h26] = 'h2E;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        cur_req = "R1";  // locked: reads zero, writes ignored
        rd_idx(); rd_dat(); idle();
        wr_idx('h12); wr_idx('hAA);
        cur_req = "R11"; wr_dat('h05); wr_dat('h0B);
        cur_req = "R2";  wr_idx('h55); rd_idx(); idle();
        cur_req = "R11"; rd_dat(); idle();

        cur_req = "R8";  get('h26); get('h07); get('h30); get('h2F);
        cur_req = "R4";  wr_idx('h40); rd_idx(); idle();
        wr_idx('h55); rd_idx(); idle();

        cur_req = "R6";
        put('h07, 3); put('h30, 'hA3); put('h80, 'h33);
        put('h07, 5); put('h30, 'hA5);
        get('h30); get('h80);
        put('h07, 3); get('h30); get('h80);

        cur_req = "R5";
        put('h10, 'h77); put('h07, 5); get('h10);
        put('h07, 9); get('h10);

        cur_req = "R7";
        put('h07, 2); put('h31, 'hB2); put('h20, 'h01); get('h31);
        put('h07, 4); get('h31);

        cur_req = "R10";
        put('h07, 'h13); get('h30); get('h07);
        put('h07, 'h0F); put('hFF, 'h5A); get('hFF);
        put('h07, 'h1F); get('hFF);

        cur_req = "R3";
        wr_idx('h2A); wr_idx('hAA); rd_idx(); idle();
        wr_idx('h55); rd_idx(); idle();

        cur_req = "R11";
        put('h07, 3); wr_idx('hAA); wr_dat('hEE); wr_idx('h30);
        wr_idx('h55); rd_dat(); idle(); get('h07);

        cur_req = "R9";
        rd_idx(); idle(); idle(); wr_idx('h09); idle(); put('h26, 'h44); idle();
        rd_dat(); wr_idx('h33); idle(); idle();

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule